// File: doc/BRIEF.md
# Host-Programmed Reset Configuration Loader

This block keeps the chip's internal power-on reset request asserted while an external host supplies the 32-bit reset configuration word. The host does not write the word in one transfer. It writes it one byte at a time over a narrow port. A host-enable strap is captured when the external power-on reset is released, and its value selects one of two boot modes. With the strap low, the block drops its internal reset on the first device clock after release and presents a built-in default word. With the strap high, the block waits for the host instead. The host must load four bytes into a single configuration address before the block lets the clock-generation lock sequence begin, and that sequence starts when the internal reset is released.

The host side runs on its own clock. Each write that hits the configuration address places the byte in a holding register on the host side and flips a toggle flag. In the device domain, the toggle passes through a two-flop synchronizer. An edge detector turns each flip into a single-cycle pulse, and the pulse commits the held byte to the next byte lane. The host must leave at least six device clocks between accepted writes, so that the held byte is stable when the device domain samples it.

Top module: `rstcfg_loader`

## Requirements
- R1: While `por_ext` is high (synchronous, active high), `por_int` is 1, `cfg_valid` is 0 and `cfg_word` is 0 from the next clock on.
- R2: The mode is taken from `strap_host_en` as sampled in the last cycle that `por_ext` is high: 1 selects host loading and 0 selects the default word.
- R3: In default mode, the first clock edge after release sets `cfg_valid` to 1, clears `por_int` to 0 and loads `cfg_word` with the parameter `DEFAULT_WORD`.
- R4: In host mode, `por_int` stays 1 and `cfg_valid` stays 0 until four accepted writes have arrived.
- R5: Accepted writes are placed least-significant byte first. Write number k (0..3) lands in `cfg_word[8k+7:8k]`.
- R6: The fourth accepted write sets `cfg_valid` and clears `por_int` on the same device clock edge. This happens no more than four device clocks after the host clock edge that captured the write.
- R7: A host write whose `host_addr` is not equal to `CFG_ADDR` (default 8'h3C) is ignored. It neither fills a lane nor advances the byte count.
- R8: Once `cfg_valid` is 1, further host writes are ignored and `cfg_word` holds its value until the next `por_ext` pulse.
- R9: Changes on `strap_host_en` after release have no effect.
- R10: A new `por_ext` pulse clears the word, the byte count and `cfg_valid`, and the strap is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| por_ext | input | 1 | External power-on reset, active high, synchronous to `clk` |
| strap_host_en | input | 1 | Host-enable strap, captured at release of `por_ext` |
| host_clk | input | 1 | Host port clock, independent of `clk` |
| host_rst | input | 1 | Host-side synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, one `host_clk` cycle per write |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write byte |
| cfg_word | output | 32 | Assembled or default configuration word |
| cfg_valid | output | 1 | Configuration word complete |
| por_int | output | 1 | Internal power-on reset request, active high |

## Verification
A fault in the byte counter or the lane select shows up at the ports as a misplaced byte in `cfg_word`. It can also appear as `por_int` falling after the wrong number of writes, and both are visible within a few device clocks of the write. A wrongly captured strap becomes visible on the first clock after release, because `por_int` either drops at once or stays high when it should not. A filter that lets stray writes through is detected in one of two ways: stray addresses shift the later bytes, and writes after completion corrupt a word that should be frozen. In both cases `cfg_word` is read back after the following write.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_FILL = 2'd1,
    LD_DONE = 2'd2
  } ld_state_t;
endpackage

// File: rtl/rstcfg_host_port.sv
// Host-domain capture: a byte holding register plus a toggle flag per accepted write.
module rstcfg_host_port #(
  parameter int                ADDR_W   = 8,
  parameter int                BYTE_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h3C
) (
  input  logic              host_clk,
  input  logic              host_rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              wr_toggle,
  output logic [BYTE_W-1:0] held_byte
);
  logic hit;
  assign hit = host_wr && (host_addr == CFG_ADDR);

  always_ff @(posedge host_clk) begin
    if (host_rst) begin
      wr_toggle <= 1'b0;
      held_byte <= '0;
    end else if (hit) begin
      wr_toggle <= ~wr_toggle;
      held_byte <= host_wdata;
    end
  end
endmodule

// File: rtl/rstcfg_toggle_sync.sv
// Multi-flop synchronizer for a toggle flag, followed by an edge detector that yields a one-cycle pulse.
module rstcfg_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic toggle_in,
  output logic pulse_out
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-1:0], toggle_in};
  end

  assign pulse_out = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/rstcfg_assembler.sv
// Device-domain strap capture, lane fill and reset extension.
module rstcfg_assembler
  import rstcfg_pkg::*;
#(
  parameter int                 BYTE_W       = 8,
  parameter int                 NUM_BYTES    = 4,
  parameter int                 WORD_W       = BYTE_W * NUM_BYTES,
  parameter logic [WORD_W-1:0]  DEFAULT_WORD = '0
) (
  input  logic              clk,
  input  logic              por_ext,
  input  logic              strap_in,
  input  logic              byte_pulse,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_valid,
  output logic              por_int
);
  localparam int                CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(NUM_BYTES - 1);

  ld_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             strap_q;
  logic             take;
  logic             load_dflt;

  assign take      = (state == LD_FILL) && byte_pulse;
  assign load_dflt = (state == LD_IDLE) && !strap_q;

  always_ff @(posedge clk) begin
    if (por_ext) begin
      state     <= LD_IDLE;
      cnt       <= '0;
      cfg_valid <= 1'b0;
      por_int   <= 1'b1;
      strap_q   <= strap_in;
    end else begin
      case (state)
        LD_IDLE: begin
          if (!strap_q) begin
            cfg_valid <= 1'b1;
            por_int   <= 1'b0;
            state     <= LD_DONE;
          end else begin
            state <= LD_FILL;
          end
        end
        LD_FILL: begin
          if (byte_pulse) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cfg_valid <= 1'b1;
              por_int   <= 1'b0;
              state     <= LD_DONE;
            end
          end
        end
        default: state <= LD_DONE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (por_ext) begin
        cfg_word[g*BYTE_W +: BYTE_W] <= '0;
      end else if (load_dflt) begin
        cfg_word[g*BYTE_W +: BYTE_W] <= DEFAULT_WORD[g*BYTE_W +: BYTE_W];
      end else if (take && (cnt == CNT_W'(g))) begin
        cfg_word[g*BYTE_W +: BYTE_W] <= byte_data;
      end
    end
  end
endmodule

// File: rtl/rstcfg_loader.sv
// Top level: host port capture, clock-domain crossing and word assembly.
module rstcfg_loader #(
  parameter int                 ADDR_W       = 8,
  parameter int                 BYTE_W       = 8,
  parameter int                 NUM_BYTES    = 4,
  parameter int                 SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0]  CFG_ADDR     = 8'h3C,
  parameter int                 WORD_W       = BYTE_W * NUM_BYTES,
  parameter logic [WORD_W-1:0]  DEFAULT_WORD = 32'h0A5C_3E01
) (
  input  logic              clk,
  input  logic              por_ext,
  input  logic              strap_host_en,
  input  logic              host_clk,
  input  logic              host_rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_valid,
  output logic              por_int
);
  logic              wr_toggle;
  logic [BYTE_W-1:0] held_byte;
  logic              byte_pulse;

  rstcfg_host_port #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_host (
    .host_clk  (host_clk),
    .host_rst  (host_rst),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .wr_toggle (wr_toggle),
    .held_byte (held_byte)
  );

  rstcfg_toggle_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .toggle_in(wr_toggle),
    .pulse_out(byte_pulse)
  );

  rstcfg_assembler #(
    .BYTE_W      (BYTE_W),
    .NUM_BYTES   (NUM_BYTES),
    .WORD_W      (WORD_W),
    .DEFAULT_WORD(DEFAULT_WORD)
  ) u_asm (
    .clk       (clk),
    .por_ext   (por_ext),
    .strap_in  (strap_host_en),
    .byte_pulse(byte_pulse),
    .byte_data (held_byte),
    .cfg_word  (cfg_word),
    .cfg_valid (cfg_valid),
    .por_int   (por_int)
  );
endmodule

// File: rtl/rstcfg_loader_chk.sv
module rstcfg_loader_chk #(
  parameter int                WORD_W       = 32,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = '0
) (
  input logic              clk,
  input logic              por_ext,
  input logic              strap_host_en,
  input logic [WORD_W-1:0] cfg_word,
  input logic              cfg_valid,
  input logic              por_int
);
  // R1: reset holds the internal request and clears the outputs
  p_reset_hold_r1: assert property (@(posedge clk)
    por_ext |=> (por_int && !cfg_valid && cfg_word == '0));

  // R3: strap low at release gives the default word one cycle later
  p_default_on_low_r3: assert property (@(posedge clk) disable iff (por_ext)
    ($past(por_ext) && !$past(strap_host_en)) |=> (cfg_valid && !por_int && cfg_word == DEFAULT_WORD));

  // R4: internal reset is only dropped together with a valid word
  p_release_needs_valid_r4: assert property (@(posedge clk) disable iff (por_ext)
    $fell(por_int) |-> cfg_valid);

  // R6: valid and release happen on the same edge
  p_valid_with_release_r6: assert property (@(posedge clk) disable iff (por_ext)
    $rose(cfg_valid) |-> $fell(por_int));

  // R8: a completed word is frozen
  p_word_frozen_r8: assert property (@(posedge clk) disable iff (por_ext)
    cfg_valid |=> (cfg_valid && $stable(cfg_word)));
endmodule

bind rstcfg_loader rstcfg_loader_chk #(
  .WORD_W      (WORD_W),
  .DEFAULT_WORD(DEFAULT_WORD)
) u_chk (
  .clk          (clk),
  .por_ext      (por_ext),
  .strap_host_en(strap_host_en),
  .cfg_word     (cfg_word),
  .cfg_valid    (cfg_valid),
  .por_int      (por_int)
);

// File: tb/rstcfg_loader_test.sv
`timescale 1ns/1ps
module rstcfg_loader_test;
  localparam logic [31:0] DFLT = 32'h0A5C_3E01;
  localparam logic [7:0]  CADR = 8'h3C;

  logic        clk = 1'b0;
  logic        host_clk = 1'b0;
  logic        por_ext = 1'b1;
  logic        strap_host_en = 1'b0;
  logic        host_rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] cfg_word;
  logic        cfg_valid;
  logic        por_int;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always #6.5 host_clk = ~host_clk;

  rstcfg_loader uut (
    .clk          (clk),
    .por_ext      (por_ext),
    .strap_host_en(strap_host_en),
    .host_clk     (host_clk),
    .host_rst     (host_rst),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .cfg_word     (cfg_word),
    .cfg_valid    (cfg_valid),
    .por_int      (por_int)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_por(input logic strap);
    @(negedge clk);
    por_ext = 1'b1;
    strap_host_en = strap;
    repeat (4) @(negedge clk);
    chk("R1 por_int in reset", {31'd0, por_int}, 32'd1);
    chk("R1 valid in reset", {31'd0, cfg_valid}, 32'd0);
    chk("R1 word in reset", cfg_word, 32'd0);
    por_ext = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge host_clk);
    host_wr = 1'b1;
    host_addr = a;
    host_wdata = d;
    @(negedge host_clk);
    host_wr = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_default_mode();
    apply_por(1'b0);
    @(negedge clk);
    chk("R3 por_int released", {31'd0, por_int}, 32'd0);
    chk("R3 valid set", {31'd0, cfg_valid}, 32'd1);
    chk("R2 R3 default word", cfg_word, DFLT);
    host_write(CADR, 8'h77);
    chk("R8 default word ignores writes", cfg_word, DFLT);
  endtask

  task automatic t_host_mode();
    apply_por(1'b1);
    repeat (5) @(negedge clk);
    chk("R2 host mode holds reset", {31'd0, por_int}, 32'd1);
    strap_host_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 strap change ignored", {31'd0, por_int}, 32'd1);
    host_write(CADR, 8'h11);
    chk("R4 after 1 write", {30'd0, por_int, cfg_valid}, 32'd2);
    host_write(CADR, 8'h22);
    host_write(8'hEE, 8'hBB);
    chk("R7 bad address not counted", {30'd0, por_int, cfg_valid}, 32'd2);
    host_write(CADR, 8'h33);
    chk("R4 after 3 writes", {30'd0, por_int, cfg_valid}, 32'd2);
    @(negedge host_clk);
    host_wr = 1'b1; host_addr = CADR; host_wdata = 8'h44;
    @(posedge host_clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6 release within bound", {30'd0, por_int, cfg_valid}, 32'd1);
    host_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 R7 assembled word", cfg_word, 32'h4433_2211);
    host_write(CADR, 8'h99);
    chk("R8 write after valid ignored", cfg_word, 32'h4433_2211);
  endtask

  task automatic t_restart();
    apply_por(1'b1);
    @(negedge clk);
    chk("R10 word cleared", cfg_word, 32'd0);
    chk("R10 count restarted", {30'd0, por_int, cfg_valid}, 32'd2);
    host_write(CADR, 8'hA5);
    host_write(CADR, 8'h5A);
    host_write(CADR, 8'hFF);
    chk("R4 R10 three writes hold", {30'd0, por_int, cfg_valid}, 32'd2);
    host_write(CADR, 8'h00);
    chk("R5 R10 second pattern", cfg_word, 32'h00FF_5AA5);
    chk("R6 second release", {30'd0, por_int, cfg_valid}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge host_clk);
    host_rst = 1'b0;
  end

  initial begin
    repeat (6) @(negedge clk);
    t_default_mode();
    t_host_mode();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule